// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block holds instructions that have already been decoded and renamed, and it releases them to execution out of program order. Each cycle the front end can write up to four instructions into free slots. Each slot records a destination physical register tag, two source tags with a ready flag for each, a two-bit operation class and a reorder-buffer index. An entry whose sources are still pending waits in the window. It becomes ready when a result broadcast carries a matching tag.

Each cycle the selection logic sends out at most two ready entries, oldest first. Age is the distance of the reorder-buffer index from the current reorder-buffer head, taken modulo 2^ROB_W, so the index may wrap. A flush request names a reorder-buffer index. In that cycle every entry younger than the index is dropped, and none of those entries is sent out. Slots of issued and flushed entries are free again at the next clock edge.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty, `issValid` is 0 and `allocReady` is 1.
- R2: `allocReady` is 1 exactly when at least four slots are free. Dispatch lanes are accepted only when `allocReady` is 1 and `flushValid` is 0. Lanes offered in any other cycle are ignored and never issue.
- R3: An entry issues only when both of its sources are ready. A source is ready on insertion when its `inSrcRdy` bit is set (bit 2k for source 0 of lane k, bit 2k+1 for source 1), or when a broadcast in the same cycle carries its tag.
- R4: A valid broadcast sets the ready flag of every waiting source whose tag matches. The entry can issue at the earliest in the cycle after the broadcast.
- R5: At most two entries issue per cycle. They are the two ready entries with the smallest age (issRob - robHead mod 2^ROB_W). Issue lane 0 carries the older one, and lane 1 is valid only when lane 0 is valid.
- R6: A ready younger entry issues ahead of an older entry that is still waiting on an operand.
- R7: Each accepted entry issues exactly once. Its slot is freed at the edge that ends its issue cycle.
- R8: While `flushValid` is 1, entries whose age is greater than the age of `flushRob` do not issue, and they are removed at the next edge. Entries at or older than `flushRob` stay.
- R9: An entry inserted with both sources ready can issue in the cycle right after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 4 | Dispatch lane valid, lane 0 oldest |
| inDst | input | 4*TAG_W | Destination tag per lane |
| inSrc0 | input | 4*TAG_W | First source tag per lane |
| inSrc1 | input | 4*TAG_W | Second source tag per lane |
| inSrcRdy | input | 8 | Source ready at insertion, bit 2k source 0 and 2k+1 source 1 of lane k |
| inCls | input | 8 | Operation class per lane |
| inRob | input | 4*ROB_W | Reorder-buffer index per lane |
| allocReady | output | 1 | At least four free slots |
| bcValid | input | BCASTS | Result broadcast valid |
| bcTag | input | BCASTS*TAG_W | Result broadcast tag |
| robHead | input | ROB_W | Reorder-buffer index of the oldest live instruction |
| flushValid | input | 1 | Squash younger entries this cycle |
| flushRob | input | ROB_W | Youngest reorder-buffer index that survives |
| issValid | output | 2 | Issue lane valid |
| issDst | output | 2*TAG_W | Destination tag per issue lane |
| issCls | output | 4 | Operation class per issue lane |
| issRob | output | 2*ROB_W | Reorder-buffer index per issue lane |

## Verification
The hardest case to reach from the ports is a flush in a cycle where some younger entries are already ready. Only that case shows that selection masks those entries as well as clearing them. The stimulus parks two entries behind one tag and two more behind another. It wakes the younger pair with a broadcast and raises the flush in the very next cycle. Age ordering across the index wrap uses the same approach: unready entries on both sides of the wrap are released together by one broadcast.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int IW_LANES  = 4;
  localparam int IW_LANE_W = 2;
  localparam int IW_PICKS  = 2;
  localparam int IW_CLS_W  = 2;

  // per-slot strobes from control to storage
  typedef struct packed {
    logic                 wr;
    logic [IW_LANE_W-1:0] lane;
    logic                 clr;
  } slot_ctl_t;
endpackage

// File: rtl/iw_ctrl.sv
module iw_ctrl
  import iw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ROB_W   = 5,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            entVld,
  input  logic [ENTRIES-1:0]            entReady,
  input  logic [ENTRIES-1:0][ROB_W-1:0] entAge,
  input  logic [IW_LANES-1:0]           inValid,
  input  logic                          flushValid,
  input  logic [ROB_W-1:0]              flushAge,
  output slot_ctl_t [ENTRIES-1:0]       ctl,
  output logic                          allocReady,
  output logic [IW_PICKS-1:0]           pickValid,
  output logic [IW_PICKS-1:0][IDX_W-1:0] pickIdx
);
  logic [ENTRIES-1:0] young;
  logic [ENTRIES-1:0] elig;
  logic               accept;
  int                 freeCnt;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      young[e] = flushValid && (entAge[e] > flushAge);
      elig[e]  = entVld[e] && entReady[e] && !young[e];
    end
  end

  assign freeCnt    = ENTRIES - $countones(entVld);
  assign allocReady = freeCnt >= IW_LANES;
  assign accept     = allocReady && !flushValid;

  // oldest two eligible entries
  always_comb begin
    pickValid = '0;
    pickIdx   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (elig[e] && (!pickValid[0] || entAge[e] < entAge[pickIdx[0]])) begin
        pickValid[0] = 1'b1;
        pickIdx[0]   = IDX_W'(e);
      end
    end
    for (int e = 0; e < ENTRIES; e++) begin
      if (elig[e] && !(pickValid[0] && pickIdx[0] == IDX_W'(e)) &&
          (!pickValid[1] || entAge[e] < entAge[pickIdx[1]])) begin
        pickValid[1] = 1'b1;
        pickIdx[1]   = IDX_W'(e);
      end
    end
  end

  // lane k goes to the k-th free slot
  always_comb begin
    int n;
    n = 0;
    for (int e = 0; e < ENTRIES; e++) begin
      ctl[e].wr   = 1'b0;
      ctl[e].lane = '0;
      ctl[e].clr  = (pickValid[0] && pickIdx[0] == IDX_W'(e)) ||
                    (pickValid[1] && pickIdx[1] == IDX_W'(e)) ||
                    (entVld[e] && young[e]);
      if (!entVld[e] && n < IW_LANES) begin
        ctl[e].wr   = accept && inValid[n];
        ctl[e].lane = n[IW_LANE_W-1:0];
        n++;
      end
    end
  end
endmodule

// File: rtl/iw_store.sv
module iw_store
  import iw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int ROB_W   = 5,
  parameter int BCASTS  = 2,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  slot_ctl_t [ENTRIES-1:0]            ctl,
  input  logic [IW_LANES-1:0][TAG_W-1:0]     laneDst,
  input  logic [IW_LANES-1:0][TAG_W-1:0]     laneSrc0,
  input  logic [IW_LANES-1:0][TAG_W-1:0]     laneSrc1,
  input  logic [IW_LANES-1:0][1:0]           laneRdy,
  input  logic [IW_LANES-1:0][IW_CLS_W-1:0]  laneCls,
  input  logic [IW_LANES-1:0][ROB_W-1:0]     laneRob,
  input  logic [BCASTS-1:0]                  bcValid,
  input  logic [BCASTS-1:0][TAG_W-1:0]       bcTags,
  input  logic [ROB_W-1:0]                   robHead,
  input  logic [IW_PICKS-1:0][IDX_W-1:0]     pickIdx,
  output logic [ENTRIES-1:0]                 entVld,
  output logic [ENTRIES-1:0]                 entReady,
  output logic [ENTRIES-1:0][ROB_W-1:0]      entAge,
  output logic [IW_PICKS-1:0][TAG_W-1:0]     pickDst,
  output logic [IW_PICKS-1:0][IW_CLS_W-1:0]  pickCls,
  output logic [IW_PICKS-1:0][ROB_W-1:0]     pickRob
);
  logic [ENTRIES-1:0][TAG_W-1:0]    dstQ, src0Q, src1Q;
  logic [ENTRIES-1:0][IW_CLS_W-1:0] clsQ;
  logic [ENTRIES-1:0][ROB_W-1:0]    robQ;
  logic [ENTRIES-1:0]               rdy0Q, rdy1Q;
  logic [ENTRIES-1:0]               wake0, wake1;
  logic [IW_LANES-1:0]              laneHit0, laneHit1;

  always_comb begin
    wake0 = '0; wake1 = '0; laneHit0 = '0; laneHit1 = '0;
    for (int b = 0; b < BCASTS; b++) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (bcValid[b] && bcTags[b] == src0Q[e]) wake0[e] = 1'b1;
        if (bcValid[b] && bcTags[b] == src1Q[e]) wake1[e] = 1'b1;
      end
      for (int k = 0; k < IW_LANES; k++) begin
        if (bcValid[b] && bcTags[b] == laneSrc0[k]) laneHit0[k] = 1'b1;
        if (bcValid[b] && bcTags[b] == laneSrc1[k]) laneHit1[k] = 1'b1;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entVld[e] <= 1'b0;
        rdy0Q[e]  <= 1'b0;
        rdy1Q[e]  <= 1'b0;
      end else if (ctl[e].wr) begin
        entVld[e] <= 1'b1;
        rdy0Q[e]  <= laneRdy[ctl[e].lane][0] | laneHit0[ctl[e].lane];
        rdy1Q[e]  <= laneRdy[ctl[e].lane][1] | laneHit1[ctl[e].lane];
      end else begin
        if (ctl[e].clr) entVld[e] <= 1'b0;
        rdy0Q[e] <= rdy0Q[e] | wake0[e];
        rdy1Q[e] <= rdy1Q[e] | wake1[e];
      end
    end

    always_ff @(posedge clk) begin
      if (ctl[e].wr) begin
        dstQ[e]  <= laneDst[ctl[e].lane];
        src0Q[e] <= laneSrc0[ctl[e].lane];
        src1Q[e] <= laneSrc1[ctl[e].lane];
        clsQ[e]  <= laneCls[ctl[e].lane];
        robQ[e]  <= laneRob[ctl[e].lane];
      end
    end

    assign entReady[e] = rdy0Q[e] & rdy1Q[e];
    assign entAge[e]   = robQ[e] - robHead;
  end

  for (genvar p = 0; p < IW_PICKS; p++) begin : g_pick
    assign pickDst[p] = dstQ[pickIdx[p]];
    assign pickCls[p] = clsQ[pickIdx[p]];
    assign pickRob[p] = robQ[pickIdx[p]];
  end
endmodule

// File: rtl/issue_window.sv
module issue_window
  import iw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int ROB_W   = 5,
  parameter int BCASTS  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [IW_LANES-1:0]           inValid,
  input  logic [IW_LANES*TAG_W-1:0]     inDst,
  input  logic [IW_LANES*TAG_W-1:0]     inSrc0,
  input  logic [IW_LANES*TAG_W-1:0]     inSrc1,
  input  logic [IW_LANES*2-1:0]         inSrcRdy,
  input  logic [IW_LANES*IW_CLS_W-1:0]  inCls,
  input  logic [IW_LANES*ROB_W-1:0]     inRob,
  output logic                          allocReady,
  input  logic [BCASTS-1:0]             bcValid,
  input  logic [BCASTS*TAG_W-1:0]       bcTag,
  input  logic [ROB_W-1:0]              robHead,
  input  logic                          flushValid,
  input  logic [ROB_W-1:0]              flushRob,
  output logic [IW_PICKS-1:0]           issValid,
  output logic [IW_PICKS*TAG_W-1:0]     issDst,
  output logic [IW_PICKS*IW_CLS_W-1:0]  issCls,
  output logic [IW_PICKS*ROB_W-1:0]     issRob
);
  localparam int IDX_W = $clog2(ENTRIES);

  slot_ctl_t [ENTRIES-1:0]             slotCtl;
  logic [ENTRIES-1:0]                  entVld, entReady;
  logic [ENTRIES-1:0][ROB_W-1:0]       entAge;
  logic [IW_PICKS-1:0][IDX_W-1:0]      pickIdx;
  logic [IW_PICKS*IDX_W-1:0]           selFlat;
  logic [IW_PICKS-1:0][TAG_W-1:0]      pickDst;
  logic [IW_PICKS-1:0][IW_CLS_W-1:0]   pickCls;
  logic [IW_PICKS-1:0][ROB_W-1:0]      pickRob;
  logic [ROB_W-1:0]                    flushAge;

  assign flushAge = flushRob - robHead;
  assign selFlat  = pickIdx;
  assign issDst   = pickDst;
  assign issCls   = pickCls;
  assign issRob   = pickRob;

  iw_ctrl #(.ENTRIES(ENTRIES), .ROB_W(ROB_W), .IDX_W(IDX_W)) ctrl_i (
    .entVld(entVld), .entReady(entReady), .entAge(entAge),
    .inValid(inValid), .flushValid(flushValid), .flushAge(flushAge),
    .ctl(slotCtl), .allocReady(allocReady),
    .pickValid(issValid), .pickIdx(pickIdx)
  );

  iw_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ROB_W(ROB_W),
             .BCASTS(BCASTS), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rstN(rstN), .ctl(slotCtl),
    .laneDst(inDst), .laneSrc0(inSrc0), .laneSrc1(inSrc1),
    .laneRdy(inSrcRdy), .laneCls(inCls), .laneRob(inRob),
    .bcValid(bcValid), .bcTags(bcTag), .robHead(robHead),
    .pickIdx(pickIdx),
    .entVld(entVld), .entReady(entReady), .entAge(entAge),
    .pickDst(pickDst), .pickCls(pickCls), .pickRob(pickRob)
  );
endmodule

// File: rtl/iw_checker.sv
module iw_checker
  import iw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ROB_W   = 5,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [IW_PICKS-1:0]        issValid,
  input logic [IW_PICKS*ROB_W-1:0]  issRob,
  input logic [ROB_W-1:0]           robHead,
  input logic                       flushValid,
  input logic [ROB_W-1:0]           flushRob,
  input logic                       allocReady,
  input logic [ENTRIES-1:0]         entVld,
  input logic [IW_PICKS*IDX_W-1:0]  selFlat
);
  logic [ROB_W-1:0] age0, age1, fAge;
  logic [IDX_W-1:0] sel0, sel1;

  assign age0 = issRob[ROB_W-1:0] - robHead;
  assign age1 = issRob[2*ROB_W-1:ROB_W] - robHead;
  assign fAge = flushRob - robHead;
  assign sel0 = selFlat[IDX_W-1:0];
  assign sel1 = selFlat[2*IDX_W-1:IDX_W];

  a_r5_lane_order: assert property (@(posedge clk) disable iff (!rstN)
    issValid[1] |-> (issValid[0] && age1 > age0));

  a_r8_flush_mask0: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && issValid[0]) |-> age0 <= fAge);

  a_r8_flush_mask1: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && issValid[1]) |-> age1 <= fAge);

  a_r2_stall_full: assert property (@(posedge clk) disable iff (!rstN)
    !allocReady |-> ($countones(entVld) > ENTRIES - IW_LANES));

  a_r7_free_lane0: assert property (@(posedge clk) disable iff (!rstN)
    issValid[0] |=> !entVld[$past(sel0)]);

  a_r7_free_lane1: assert property (@(posedge clk) disable iff (!rstN)
    issValid[1] |=> !entVld[$past(sel1)]);
endmodule

bind issue_window iw_checker #(.ENTRIES(ENTRIES), .ROB_W(ROB_W), .IDX_W($clog2(ENTRIES))) chk_i (
  .clk(clk), .rstN(rstN), .issValid(issValid), .issRob(issRob),
  .robHead(robHead), .flushValid(flushValid), .flushRob(flushRob),
  .allocReady(allocReady), .entVld(entVld), .selFlat(selFlat)
);

// File: tb/issue_window_tb.sv
module issue_window_tb_top;
  localparam int TW = 6;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    inValid = '0;
  logic [4*TW-1:0] inDst = '0, inSrc0 = '0, inSrc1 = '0;
  logic [7:0]    inSrcRdy = '0;
  logic [7:0]    inCls = '0;
  logic [4*RW-1:0] inRob = '0;
  logic          allocReady;
  logic [1:0]    bcValid = '0;
  logic [2*TW-1:0] bcTag = '0;
  logic [RW-1:0] robHead = '0;
  logic          flushValid = 1'b0;
  logic [RW-1:0] flushRob = '0;
  logic [1:0]    issValid;
  logic [2*TW-1:0] issDst;
  logic [3:0]    issCls;
  logic [2*RW-1:0] issRob;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  issue_window dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDst(inDst),
    .inSrc0(inSrc0), .inSrc1(inSrc1), .inSrcRdy(inSrcRdy), .inCls(inCls),
    .inRob(inRob), .allocReady(allocReady), .bcValid(bcValid), .bcTag(bcTag),
    .robHead(robHead), .flushValid(flushValid), .flushRob(flushRob),
    .issValid(issValid), .issDst(issDst), .issCls(issCls), .issRob(issRob)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    inValid = '0; inSrcRdy = '0; bcValid = '0; flushValid = 1'b0;
  endtask

  task automatic setLane(int k, int s0, int s1, bit r0, bit r1, int rob);
    inValid[k] = 1'b1;
    inDst[k*TW +: TW]  = TW'(rob + 32);
    inSrc0[k*TW +: TW] = TW'(s0);
    inSrc1[k*TW +: TW] = TW'(s1);
    inSrcRdy[2*k]      = r0;
    inSrcRdy[2*k+1]    = r1;
    inCls[2*k +: 2]    = 2'(rob);
    inRob[k*RW +: RW]  = RW'(rob);
  endtask

  task automatic bcast(int b, int tag);
    bcValid[b] = 1'b1;
    bcTag[b*TW +: TW] = TW'(tag);
  endtask

  // scoreboard monitor: every issued index must be the next expected one (R5 R6 R7)
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int l = 0; l < 2; l++) begin
        if (issValid[l]) begin
          int act;
          int e;
          act = int'(issRob[l*RW +: RW]);
          e = (expQ.size() > 0) ? expQ.pop_front() : -1;
          check(act == e, "R5 R6 R7 issue order", act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(allocReady == 1'b1, "R1 allocReady", allocReady, 1);
    check(issValid == 2'b00, "R1 issValid", issValid, 0);

    // four ready instructions in one cycle
    tick(); clearIn();
    for (int k = 0; k < 4; k++) setLane(k, 1, 2, 1'b1, 1'b1, k);
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2); expQ.push_back(3);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b11 && issRob[RW-1:0] == 0, "R9 issue right after write", int'(issValid), 3);
    tick(); tick();

    // younger ready ones bypass older waiting ones
    setLane(0, 10, 2, 1'b0, 1'b1, 4);
    setLane(1, 1, 2, 1'b1, 1'b1, 5);
    setLane(2, 3, 11, 1'b1, 1'b0, 6);
    setLane(3, 1, 2, 1'b1, 1'b1, 7);
    expQ.push_back(5); expQ.push_back(7);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b11 && issRob[2*RW-1:RW] == 7, "R6 bypass", int'(issRob[2*RW-1:RW]), 7);
    tick(); tick();
    bcast(0, 11);
    expQ.push_back(6);
    @(negedge clk);
    check(issValid == 2'b00, "R4 no issue in broadcast cycle", int'(issValid), 0);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b01 && issRob[RW-1:0] == 6, "R4 wake next cycle", int'(issRob[RW-1:0]), 6);
    tick();
    bcast(1, 10);
    expQ.push_back(4);
    tick(); clearIn();
    tick();

    // same-cycle broadcast at insertion
    setLane(0, 12, 2, 1'b0, 1'b1, 8);
    bcast(0, 12);
    expQ.push_back(8);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b01 && issRob[RW-1:0] == 8, "R3 insert-time wake", int'(issValid), 1);
    tick();

    // allocation stall
    for (int k = 0; k < 4; k++) setLane(k, 20, 2, 1'b0, 1'b1, 9 + k);
    tick(); clearIn();
    @(negedge clk);
    check(allocReady == 1'b1, "R2 four free", allocReady, 1);
    tick();
    setLane(0, 20, 2, 1'b0, 1'b1, 13);
    tick(); clearIn();
    @(negedge clk);
    check(allocReady == 1'b0, "R2 three free stalls", allocReady, 0);
    tick();
    setLane(0, 1, 2, 1'b1, 1'b1, 14);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b00, "R2 lane ignored while stalled", int'(issValid), 0);
    check(allocReady == 1'b0, "R2 still stalled", allocReady, 0);
    tick();
    bcast(1, 20);
    for (int r = 9; r <= 13; r++) expQ.push_back(r);
    tick(); clearIn();
    repeat (4) tick();
    @(negedge clk);
    check(allocReady == 1'b1, "R2 stall released", allocReady, 1);
    tick();

    // flush with ready younger entries
    setLane(0, 30, 2, 1'b0, 1'b1, 15);
    setLane(1, 30, 2, 1'b0, 1'b1, 16);
    setLane(2, 31, 2, 1'b0, 1'b1, 17);
    setLane(3, 31, 2, 1'b0, 1'b1, 18);
    tick(); clearIn();
    bcast(0, 31);
    tick(); clearIn();
    flushValid = 1'b1; flushRob = 5'd16;
    setLane(0, 1, 2, 1'b1, 1'b1, 19);
    @(negedge clk);
    check(issValid == 2'b00, "R8 younger masked in flush cycle", int'(issValid), 0);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b00, "R8 younger removed", int'(issValid), 0);
    tick();
    bcast(0, 30);
    expQ.push_back(15); expQ.push_back(16);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b11 && issRob[RW-1:0] == 15, "R8 older entries kept", int'(issRob[RW-1:0]), 15);
    repeat (3) tick();

    // age order across index wrap
    robHead = 5'd28;
    setLane(0, 41, 2, 1'b0, 1'b1, 29);
    setLane(1, 41, 2, 1'b0, 1'b1, 30);
    setLane(2, 41, 2, 1'b0, 1'b1, 31);
    setLane(3, 41, 2, 1'b0, 1'b1, 0);
    expQ.push_back(29); expQ.push_back(30); expQ.push_back(31); expQ.push_back(0);
    tick(); clearIn();
    bcast(1, 41);
    tick(); clearIn();
    @(negedge clk);
    check(issValid == 2'b11 && issRob[RW-1:0] == 29, "R5 oldest across wrap", int'(issRob[RW-1:0]), 29);
    tick();
    @(negedge clk);
    check(issValid == 2'b11 && issRob[2*RW-1:RW] == 0, "R5 wrapped index last", int'(issRob[2*RW-1:RW]), 0);
    repeat (4) tick();
    check(expQ.size() == 0, "R7 all issued once", expQ.size(), 0);
    check(allocReady == 1'b1, "R7 slots freed", allocReady, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule